// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management interface. It sends Clause 22 frames to external PHYs. Software places an opcode, a PHY address, a register address and write data in a command word. Setting the launch bit in the same write starts the frame. The block then runs the management clock from the system clock through a programmable divider. It drives the data line through separate value and enable outputs and samples the line through its own input, so the pad cell stays outside the block.

The launch bit stays set for the whole frame and drops when the last bit has been clocked. After a read, the low half of the command word holds the 16 bits returned by the PHY. If the PHY does not pull the line low in the second turnaround slot, a failure flag is raised at completion. A configuration word sets the divider and can remove the 32-bit preamble so that frames are shorter.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word (byte address 0) reads 0, the configuration word (byte address 4) reads 0x0000_0001 (divider 0, preamble on, Clause 22 bit set), MDC is high and the data enable is low.
- R2: The command word layout is: bit 29 launch/busy, bit 28 read failure (read-only, software writes to it are dropped), bits 27:26 opcode, 25:21 PHY address, 20:16 register address, 15:0 data. A write with bit 29 clear stores the fields without starting a frame.
- R3: A write with bit 29 set while idle starts a frame. Bit 29 reads 1 until the rising MDC edge of the last frame bit, which comes exactly 2 × bits × (div+1) clock cycles after the launching edge. Here bits is 64 with preamble and 32 without. The data enable is low whenever no frame is running.
- R4: MDC toggles every div+1 clock cycles while a frame runs, starting high and falling first. MDC stays high when idle.
- R5: The frame is sent MSB first in this order: 32 ones of preamble, start 01, the opcode, the PHY address, the register address, a turnaround of 10 for writes, then the 16 data bits.
- R6: Configuration bit 12 set removes the preamble, and the frame begins with the start pattern.
- R7: The data output changes only on a falling MDC edge. The input is sampled on rising MDC edges.
- R8: For opcode 10 (read), the enable drops from the first turnaround bit to the end of the frame. The 16 bits sampled during the data phase replace bits 15:0 of the command word at completion.
- R9: If the line is high at the second turnaround bit of a read, bit 28 is set at completion.
- R10: Command-word writes while busy are ignored, including their launch bit. Bit 28 is cleared when a new frame starts.
- R11: Configuration word layout: bit 0 Clause 22 select (stored), bits 9:4 divider, bit 12 preamble suppress. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Sampled state of the data line |

## Verification
The assertions assume that the configuration word is not rewritten while a frame runs. A divider change mid-frame would stretch or shorten a half period, which the timing checks do not allow for. They also assume that mdio_in follows the pad, meaning it loops back mdio_out whenever the enable is high. The bench writes the configuration only between frames and models the line as exactly that loopback. When the enable is low, a PHY model answers with a turnaround zero and data, or leaves the line floating high to produce the failure case. The ignored-write case puts a launching write with every field set in the middle of a running frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W    = 6;
    localparam int IDX_W    = 6;
    localparam int FRAME_W  = 64;
    localparam int PRE_W    = 32;
    localparam int DATA_W   = 16;
    localparam int BIT_BUSY = 29;

    localparam logic [1:0] OP_RD = 2'b10;

    localparam logic [IDX_W-1:0] IDX_TA_HI    = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_TA_LO    = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_DATA_TOP = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic             nopre;
        logic [DIV_W-1:0] div;
        logic             cl22;
    } cfg_t;

    function automatic logic [FRAME_W-1:0] frame_of(cmd_t c);
        logic [1:0] ta;
        ta = (c.op == OP_RD) ? 2'b11 : 2'b10;
        return {{PRE_W{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, c.data};
    endfunction

    function automatic logic [IDX_W-1:0] first_idx(logic nopre);
        return nopre ? IDX_W'(PRE_W - 1) : IDX_W'(FRAME_W - 1);
    endfunction

    function automatic logic [31:0] cmd_word(logic busy, logic fail, cmd_t c);
        return {2'b00, busy, fail, c};
    endfunction

    function automatic logic [31:0] cfg_word(cfg_t g);
        return {19'b0, g.nopre, 2'b00, g.div, 3'b000, g.cl22};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall,
    output logic             rise
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = run && (cnt == div);
    assign fall = wrap && mdc;
    assign rise = wrap && !mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b1;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [IDX_W-1:0]   idx_init,
    input  logic               rd_in,
    input  logic               fall,
    input  logic               rise,
    input  logic               mdio_in,
    output logic               mdo,
    output logic               oe,
    output logic               done,
    output logic [DATA_W-1:0]  rd_word,
    output logic               ta_bad
);
    logic [FRAME_W-1:0] frame_q;
    logic               rd_q;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-2:0]  sh;
    logic               listen;

    assign listen  = rd_q && (idx <= IDX_TA_HI);
    assign done    = rise && (idx == '0);
    assign rd_word = {sh, mdio_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            rd_q    <= 1'b0;
            idx     <= '0;
            sh      <= '0;
            mdo     <= 1'b1;
            oe      <= 1'b0;
            ta_bad  <= 1'b0;
        end else if (start) begin
            frame_q <= frame_in;
            rd_q    <= rd_in;
            idx     <= idx_init;
            ta_bad  <= 1'b0;
        end else begin
            if (fall) begin
                mdo <= frame_q[idx];
                oe  <= !listen;
            end
            if (rise) begin
                if (rd_q && (idx == IDX_TA_LO) && mdio_in)
                    ta_bad <= 1'b1;
                if (idx <= IDX_DATA_TOP)
                    sh <= {sh[DATA_W-3:0], mdio_in};
                if (idx == '0)
                    oe <= 1'b0;
                else
                    idx <= idx - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4);

    cmd_t  cmd_q;
    cfg_t  cfg_q;
    cmd_t  cmd_new;
    logic  busy_q;
    logic  fail_q;
    logic  cmd_wr_any;
    logic  cmd_wr;
    logic  launch;
    logic  tick_fall;
    logic  tick_rise;
    logic  eng_done;
    logic  eng_ta_bad;
    logic [DATA_W-1:0] eng_word;
    logic  unused_wdata;

    assign unused_wdata = |reg_wdata[31:30];
    assign cmd_new      = cmd_t'(reg_wdata[27:0]);
    assign cmd_wr_any   = reg_wr && (reg_addr == A_CMD);
    assign cmd_wr       = cmd_wr_any && !busy_q;
    assign launch       = cmd_wr && reg_wdata[BIT_BUSY];

    always_comb begin
        if (reg_addr == A_CMD)      reg_rdata = cmd_word(busy_q, fail_q, cmd_q);
        else if (reg_addr == A_CFG) reg_rdata = cfg_word(cfg_q);
        else                        reg_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            cfg_q  <= '{nopre: 1'b0, div: '0, cl22: 1'b1};
            busy_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (eng_done) begin
                busy_q <= 1'b0;
                if (cmd_q.op == OP_RD) begin
                    cmd_q.data <= eng_word;
                    fail_q     <= eng_ta_bad;
                end
            end
            if (cmd_wr) begin
                cmd_q <= cmd_new;
                if (launch) begin
                    busy_q <= 1'b1;
                    fail_q <= 1'b0;
                end
            end
            if (reg_wr && (reg_addr == A_CFG))
                cfg_q <= '{nopre: reg_wdata[12], div: reg_wdata[9:4], cl22: reg_wdata[0]};
        end
    end

    mdio_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q),
        .div  (cfg_q.div),
        .mdc  (mdc),
        .fall (tick_fall),
        .rise (tick_rise)
    );

    mdio_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .frame_in (frame_of(cmd_new)),
        .idx_init (first_idx(cfg_q.nopre)),
        .rd_in    (cmd_new.op == OP_RD),
        .fall     (tick_fall),
        .rise     (tick_rise),
        .mdio_in  (mdio_in),
        .mdo      (mdio_out),
        .oe       (mdio_oe),
        .done     (eng_done),
        .rd_word  (eng_word),
        .ta_bad   (eng_ta_bad)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        busy,
    input logic        mdo,
    input logic        oe,
    input logic        fail,
    input logic        done,
    input logic        cmd_wr,
    input logic [27:0] cmd_bits
);
    a_r4_idle_mdc_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mdc);

    a_r4_mdc_moves_when_busy: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdc) |-> $past(busy));

    a_r7_mdo_changes_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && !$stable(mdo)) |-> $fell(mdc));

    a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
        oe |-> busy);

    a_r3_busy_ends_on_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $rose(mdc));

    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr && !done) |=> $stable(cmd_bits));

    a_r10_fail_cleared_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !fail);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .busy     (busy_q),
    .mdo      (mdio_out),
    .oe       (mdio_oe),
    .fail     (fail_q),
    .done     (eng_done),
    .cmd_wr   (cmd_wr_any),
    .cmd_bits (cmd_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;
    logic        phy_line = 1'b1;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_in = mdio_oe ? mdio_out : phy_line;

    mdio_master u_mdio_master (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Behavioural model of one frame, compared every cycle.
    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] dat, input int div, input bit nopre,
                             input bit respond, input logic [15:0] pval, input bit inject);
        logic [63:0] fr;
        logic [31:0] word;
        int bits, dd, tt, h, j, pos;
        bit is_rd, low, exp_oe;
        logic [15:0] exp_data;
        wr(3'd4, {19'b0, nopre, 2'b00, 6'(div), 3'b000, 1'b1});
        @(negedge clk);
        reg_addr  = 3'd0;
        reg_wdata = {2'b00, 1'b1, 1'b0, op, phy, rg, dat};
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        bits  = nopre ? 32 : 64;
        dd    = div + 1;
        tt    = 2 * bits * dd;
        is_rd = (op == 2'b10);
        fr    = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, dat};
        for (int n = 0; n <= tt; n++) begin
            h   = n / dd;
            low = (n < tt) && (h % 2 == 1);
            pos = -1;
            if (low) begin
                j   = (h - 1) / 2;
                pos = bits - 1 - j;
            end
            phy_line = 1'b1;
            if (low && is_rd && pos <= 16) begin
                if (pos == 16) phy_line = respond ? 1'b0 : 1'b1;
                else           phy_line = respond ? pval[pos] : 1'b1;
            end
            if (inject && n == 3) begin
                reg_addr  = 3'd0;
                reg_wdata = 32'h3FFF_FFFF;
                reg_wr    = 1'b1;
            end
            if (inject && n == 4) reg_wr = 1'b0;
            #1;
            chk("R3 busy bit", 32'(reg_rdata[29]), 32'(n < tt));
            chk("R4 mdc level", 32'(mdc), 32'((n >= tt) || (h % 2 == 0)));
            if (n == 1) chk("R10 fail cleared at start", 32'(reg_rdata[28]), 32'd0);
            if (low) begin
                exp_oe = !(is_rd && pos <= 17);
                chk("R8 drive enable", 32'(mdio_oe), 32'(exp_oe));
                if (exp_oe) chk(nopre ? "R6 frame bit" : "R5 frame bit", 32'(mdio_out), 32'(fr[pos]));
            end
            @(negedge clk);
        end
        phy_line = 1'b1;
        reg_addr = 3'd0;
        #1;
        word = reg_rdata;
        exp_data = is_rd ? (respond ? pval : 16'hFFFF) : dat;
        if (is_rd) chk("R9 fail flag", 32'(word[28]), 32'(!respond));
        chk(is_rd ? "R8 read result" : "R10 command word kept", word,
            {2'b00, 1'b0, is_rd && !respond, op, phy, rg, exp_data});
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, v); chk("R1 command reset", v, 32'h0);
        rd(3'd4, v); chk("R1 config reset", v, 32'h0000_0001);
        chk("R1 mdc idle", 32'(mdc), 32'd1);
        chk("R1 enable idle", 32'(mdio_oe), 32'd0);
        // R11 configuration layout
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R11 config fields", v, 32'h0000_13F1);
        wr(3'd4, 32'h0000_0001);
        rd(3'd4, v); chk("R11 config restore", v, 32'h0000_0001);
        // R2 fields stored without launch, fail bit not writable
        wr(3'd0, 32'h0A5A_1234);
        rd(3'd0, v); chk("R2 field store", v, 32'h0A5A_1234);
        repeat (4) @(negedge clk);
        chk("R4 mdc stays high idle", 32'(mdc), 32'd1);
        rd(3'd0, v); chk("R2 no launch", v, 32'h0A5A_1234);
        wr(3'd0, 32'h1000_0000);
        rd(3'd0, v); chk("R2 fail bit read-only", v, 32'h0);
        // Frames
        run_frame(2'b01, 5'h11, 5'h0A, 16'hBEEF, 0, 1'b0, 1'b0, 16'h0, 1'b0);
        run_frame(2'b01, 5'h03, 5'h1F, 16'h8001, 2, 1'b1, 1'b0, 16'h0, 1'b1);
        run_frame(2'b10, 5'h1C, 5'h02, 16'h0000, 1, 1'b0, 1'b1, 16'hA5C3, 1'b0);
        run_frame(2'b10, 5'h07, 5'h15, 16'h0000, 0, 1'b1, 1'b0, 16'h0, 1'b0);
        run_frame(2'b10, 5'h00, 5'h01, 16'h0000, 3, 1'b1, 1'b1, 16'h1234, 1'b1);
        run_frame(2'b01, 5'h1F, 5'h00, 16'h0F0F, 5, 1'b1, 1'b0, 16'h0, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule